// File: doc/BRIEF.md
# Configurable Logic Macrocell

This block models one output cell of a small programmable logic device, with its configuration held on static inputs. A sum-of-products term arrives from the logic array. One storage element then handles it in the way a two-bit mode field sets: an edge-triggered D register, an edge-triggered toggle register, a level-sensitive transparent latch, or a plain combinational bypass. The clock for that element comes from one of several global clocks or from a clock built by a product term. A block-wide asynchronous reset and a block-wide asynchronous preset override the stored value at any time.

The cell's result goes two ways. It goes back, uninverted, to the routing fabric as a feedback signal. It also goes to the pin after an optional inversion, so the pin can be active high or active low. A buried setting isolates the pin and takes the storage element's data from the neighbouring cell's pin, so the cell acts as an input register or input latch. The pin driver's enable is chosen from a constant off, a constant on, or one of the shared enable lines. Configuration is expected to be held steady while the cell runs.

Top module: `mc_cell`

## Requirements
- R1: With mode code 2'b00 the stored bit takes the selected data input on each rising edge of the selected clock and holds between edges.
- R2: With mode code 2'b01 the stored bit inverts on a rising edge of the selected clock when the data input is 1 and holds when it is 0.
- R3: With mode code 2'b10 the stored bit follows the data input while the selected clock is high and holds while it is low.
- R4: With mode code 2'b11 the result equals the selected data input combinationally, and neither clock nor reset/preset affects it.
- R5: Clock select code i below NUM_GCLK picks global clock gClk[i]; every code from NUM_GCLK upward picks ptClk; unselected clocks have no effect.
- R6: asyncRst forces the stored bit to 0 and asyncSet forces it to 1 without any clock; when both are high the bit is 0.
- R7: pinOut equals the result when cfgInvert is 0 and its complement when cfgInvert is 1.
- R8: With cfgBuried at 1 the data input is nbrPin and sumTerm has no effect; with cfgBuried at 0 the data input is sumTerm.
- R9: feedback always equals the uninverted result, in every mode and in buried and unburied operation.
- R10: pinOe is 0 for enable select code 0, 1 for code 1, oeShared[k] for code 2+k, 0 for codes beyond the shared lines, and 0 whenever cfgBuried is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| gClk | input | NUM_GCLK | Global synchronous clocks |
| ptClk | input | 1 | Product-term generated clock |
| asyncRst | input | 1 | Block-wide asynchronous reset term |
| asyncSet | input | 1 | Block-wide asynchronous preset term |
| sumTerm | input | 1 | Sum-of-products data from the logic array |
| nbrPin | input | 1 | Input from the neighbouring cell's pin (buried mode data) |
| oeShared | input | NUM_OE | Shared output enable lines |
| cfgMode | input | 2 | Storage mode: 00 D, 01 toggle, 10 latch, 11 bypass |
| cfgClkSel | input | CLK_SEL_W | Clock source select |
| cfgInvert | input | 1 | Output polarity: 1 inverts the pin output |
| cfgBuried | input | 1 | Buried input-register mode |
| cfgOeSel | input | OE_SEL_W | Output enable source select |
| pinOut | output | 1 | Value sent to the pin driver |
| pinOe | output | 1 | Pin driver enable |
| feedback | output | 1 | Uninverted result routed back to the interconnect |

## Verification
The bench builds the cell with its defaults: four global clocks and two shared enables. This makes the clock select three bits wide. Select codes 5 to 7 are then aliases of the product-term clock, and the bench drives code 7 to check that the alias reaches it. Every enable select code is a legal value. Each clock toggles at its own rate, so a run in which one clock drives the cell also shows that the other clocks have no effect. The reset, preset and overlap sequences are applied in each storage mode to show the priority order.

// File: rtl/mc_pkg.sv
package mc_pkg;

  typedef enum logic [1:0] {
    MODE_DFF   = 2'b00,
    MODE_TFF   = 2'b01,
    MODE_LATCH = 2'b10,
    MODE_COMB  = 2'b11
  } mode_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic toggle;   // edge element inverts instead of loading
    logic latch;    // result taken from the level-sensitive element
    logic bypass;   // result taken straight from the data input
    logic fromNbr;  // data input comes from the neighbouring pin
    logic invert;   // pin polarity inversion
  } strobe_t;

endpackage

// File: rtl/mc_ctrl.sv
module mc_ctrl
  import mc_pkg::*;
#(
  parameter int NUM_GCLK  = 4,
  parameter int NUM_OE    = 2,
  parameter int CLK_SEL_W = 3,
  parameter int OE_SEL_W  = 2
) (
  input  logic [NUM_GCLK-1:0]  gClk,
  input  logic                 ptClk,
  input  logic [NUM_OE-1:0]    oeShared,
  input  logic [1:0]           cfgMode,
  input  logic [CLK_SEL_W-1:0] cfgClkSel,
  input  logic                 cfgInvert,
  input  logic                 cfgBuried,
  input  logic [OE_SEL_W-1:0]  cfgOeSel,
  output logic                 selClk,
  output strobe_t              strobe,
  output logic                 pinOe
);

  mode_e modeDec;
  assign modeDec = mode_e'(cfgMode);

  // Clock source: the product-term clock unless a global clock index matches
  always_comb begin
    selClk = ptClk;
    for (int i = 0; i < NUM_GCLK; i++) begin
      if (cfgClkSel == CLK_SEL_W'(i)) selClk = gClk[i];
    end
  end

  always_comb begin
    strobe.toggle  = (modeDec == MODE_TFF);
    strobe.latch   = (modeDec == MODE_LATCH);
    strobe.bypass  = (modeDec == MODE_COMB);
    strobe.fromNbr = cfgBuried;
    strobe.invert  = cfgInvert;
  end

  // Enable source: code 0 off, code 1 on, code 2+k shared line k
  logic oeRaw;
  always_comb begin
    oeRaw = 1'b0;
    if (cfgOeSel == OE_SEL_W'(1)) oeRaw = 1'b1;
    for (int k = 0; k < NUM_OE; k++) begin
      if (cfgOeSel == OE_SEL_W'(k + 2)) oeRaw = oeShared[k];
    end
  end

  assign pinOe = oeRaw & ~cfgBuried;

endmodule

// File: rtl/mc_datapath.sv
module mc_datapath
  import mc_pkg::*;
(
  input  logic    selClk,
  input  logic    asyncRst,
  input  logic    asyncSet,
  input  logic    sumTerm,
  input  logic    nbrPin,
  input  strobe_t strobe,
  output logic    pinOut,
  output logic    feedback
);

  logic dataIn;
  logic edgeQ;
  logic levelQ;
  logic result;

  assign dataIn = strobe.fromNbr ? nbrPin : sumTerm;

  // Edge-triggered element: D load or toggle
  always_ff @(posedge selClk or posedge asyncRst or posedge asyncSet) begin
    if (asyncRst)          edgeQ <= 1'b0;
    else if (asyncSet)     edgeQ <= 1'b1;
    else if (strobe.toggle) edgeQ <= edgeQ ^ dataIn;
    else                   edgeQ <= dataIn;
  end

  // Level-sensitive element: transparent while the selected clock is high
  always_latch begin
    if (asyncRst)      levelQ = 1'b0;
    else if (asyncSet) levelQ = 1'b1;
    else if (selClk)   levelQ = dataIn;
  end

  always_comb begin
    if (strobe.bypass)     result = dataIn;
    else if (strobe.latch) result = levelQ;
    else                   result = edgeQ;
  end

  assign feedback = result;
  assign pinOut   = result ^ strobe.invert;

endmodule

// File: rtl/mc_cell.sv
module mc_cell
  import mc_pkg::*;
#(
  parameter int NUM_GCLK = 4,
  parameter int NUM_OE   = 2,
  localparam int CLK_SEL_W = $clog2(NUM_GCLK + 1),
  localparam int OE_SEL_W  = $clog2(NUM_OE + 2)
) (
  input  logic [NUM_GCLK-1:0]  gClk,
  input  logic                 ptClk,
  input  logic                 asyncRst,
  input  logic                 asyncSet,
  input  logic                 sumTerm,
  input  logic                 nbrPin,
  input  logic [NUM_OE-1:0]    oeShared,
  input  logic [1:0]           cfgMode,
  input  logic [CLK_SEL_W-1:0] cfgClkSel,
  input  logic                 cfgInvert,
  input  logic                 cfgBuried,
  input  logic [OE_SEL_W-1:0]  cfgOeSel,
  output logic                 pinOut,
  output logic                 pinOe,
  output logic                 feedback
);

  logic    selClk;
  strobe_t strobe;

  mc_ctrl #(
    .NUM_GCLK (NUM_GCLK),
    .NUM_OE   (NUM_OE),
    .CLK_SEL_W(CLK_SEL_W),
    .OE_SEL_W (OE_SEL_W)
  ) u_ctrl (
    .gClk     (gClk),
    .ptClk    (ptClk),
    .oeShared (oeShared),
    .cfgMode  (cfgMode),
    .cfgClkSel(cfgClkSel),
    .cfgInvert(cfgInvert),
    .cfgBuried(cfgBuried),
    .cfgOeSel (cfgOeSel),
    .selClk   (selClk),
    .strobe   (strobe),
    .pinOe    (pinOe)
  );

  mc_datapath u_dp (
    .selClk  (selClk),
    .asyncRst(asyncRst),
    .asyncSet(asyncSet),
    .sumTerm (sumTerm),
    .nbrPin  (nbrPin),
    .strobe  (strobe),
    .pinOut  (pinOut),
    .feedback(feedback)
  );

endmodule

// File: rtl/mc_cell_chk.sv
module mc_cell_chk (
  input logic       selClk,
  input logic       asyncRst,
  input logic       asyncSet,
  input logic [1:0] cfgMode,
  input logic       cfgBuried,
  input logic       cfgInvert,
  input logic       sumTerm,
  input logic       pinOut,
  input logic       pinOe,
  input logic       feedback
);

  // R1: D mode loads the unburied data on each edge
  assert_dff_load_R1: assert property (@(posedge selClk) disable iff (asyncRst || asyncSet)
    (cfgMode == 2'b00 && !cfgBuried) |=> (feedback == $past(sumTerm)));

  // R2: toggle mode inverts when data is 1
  assert_tff_step_R2: assert property (@(posedge selClk) disable iff (asyncRst || asyncSet)
    (cfgMode == 2'b01 && !cfgBuried) |=> (feedback == ($past(feedback) ^ $past(sumTerm))));

  // R6: reset holds the stored bit at 0 in every storing mode
  assert_rst_clear_R6: assert property (@(posedge selClk) disable iff (cfgMode == 2'b11)
    asyncRst |-> (feedback == 1'b0));

  // R7: pin polarity relative to feedback
  assert_polarity_R7: assert property (@(posedge selClk) disable iff (asyncRst)
    1'b1 |-> (pinOut == (feedback ^ cfgInvert)));

  // R10: buried cell never drives its pin
  assert_buried_off_R10: assert property (@(posedge selClk) disable iff (asyncRst)
    cfgBuried |-> !pinOe);

endmodule

bind mc_cell mc_cell_chk u_chk (
  .selClk   (selClk),
  .asyncRst (asyncRst),
  .asyncSet (asyncSet),
  .cfgMode  (cfgMode),
  .cfgBuried(cfgBuried),
  .cfgInvert(cfgInvert),
  .sumTerm  (sumTerm),
  .pinOut   (pinOut),
  .pinOe    (pinOe),
  .feedback (feedback)
);

// File: tb/mc_cell_test.sv
`timescale 1ns/100ps
module mc_cell_test;

  logic       tick = 1'b0;
  always #2 tick = ~tick;   // 250 MHz

  logic [3:0] gClk = '0;
  logic       ptClk = 1'b0;
  logic       asyncRst = 1'b1;
  logic       asyncSet = 1'b0;
  logic       sumTerm = 1'b0;
  logic       nbrPin = 1'b0;
  logic [1:0] oeShared = '0;
  logic [1:0] cfgMode = 2'b00;
  logic [2:0] cfgClkSel = '0;
  logic       cfgInvert = 1'b0;
  logic       cfgBuried = 1'b0;
  logic [1:0] cfgOeSel = '0;
  logic       pinOut, pinOe, feedback;

  mc_cell uut (
    .gClk(gClk), .ptClk(ptClk), .asyncRst(asyncRst), .asyncSet(asyncSet),
    .sumTerm(sumTerm), .nbrPin(nbrPin), .oeShared(oeShared), .cfgMode(cfgMode),
    .cfgClkSel(cfgClkSel), .cfgInvert(cfgInvert), .cfgBuried(cfgBuried),
    .cfgOeSel(cfgOeSel), .pinOut(pinOut), .pinOe(pinOe), .feedback(feedback)
  );

  int total = 0;
  int bad = 0;
  int stepNo = 0;
  int tickCount = 0;
  logic [15:0] lfsr = 16'hACE1;

  // behavioural model state
  bit mEdge = 0, mLevel = 0, prevSel = 0;

  always @(posedge tick) begin
    tickCount++;
    if (tickCount > 150000) begin
      bad++; total++;
      $display("FAIL watchdog: run did not finish, got %0d ticks exp fewer", tickCount);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  function automatic bit pickClk(input logic [3:0] g, input logic p, input logic [2:0] s);
    if (s < 3'd4) return g[s];
    return p;
  endfunction

  task automatic step(input bit rst, input bit set, input string tag);
    bit din, newSel, expRes, expOe;
    @(posedge tick);
    #0.5;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    asyncRst = rst;
    asyncSet = set;
    sumTerm  = lfsr[0];
    nbrPin   = lfsr[5];
    oeShared = lfsr[9:8];
    din = cfgBuried ? nbrPin : sumTerm;
    if (rst) begin mEdge = 0; mLevel = 0; end
    else if (set) begin mEdge = 1; mLevel = 1; end
    else if (prevSel) mLevel = din;
    #0.5;
    stepNo++;
    for (int k = 0; k < 4; k++) gClk[k] = ((stepNo / (k + 1)) % 2) == 1;
    ptClk = ((stepNo / 5) % 2) == 1;
    newSel = pickClk(gClk, ptClk, cfgClkSel);
    if (!rst && !set) begin
      if (!prevSel && newSel) mEdge = (cfgMode == 2'b01) ? (mEdge ^ din) : din;
      if (newSel) mLevel = din;
    end
    prevSel = newSel;
    case (cfgMode)
      2'b10:   expRes = mLevel;
      2'b11:   expRes = din;
      default: expRes = mEdge;
    endcase
    case (cfgOeSel)
      2'd0: expOe = 0;
      2'd1: expOe = 1;
      default: expOe = oeShared[cfgOeSel - 2];
    endcase
    if (cfgBuried) expOe = 0;
    @(negedge tick);
    total++;
    if (feedback !== expRes || pinOut !== (expRes ^ cfgInvert) || pinOe !== expOe) begin
      bad++;
      $display("FAIL %s step %0d: feedback (R9) got %b exp %b, pinOut (R7) got %b exp %b, pinOe (R10) got %b exp %b",
               tag, stepNo, feedback, expRes, pinOut, expRes ^ cfgInvert, pinOe, expOe);
    end
  endtask

  task automatic runPhase(input logic [1:0] mode, input logic [2:0] cs, input bit inv,
                          input bit bur, input logic [1:0] oe, input bit doAsync,
                          input string tag);
    asyncRst = 1'b1;
    cfgMode = mode; cfgClkSel = cs; cfgInvert = inv; cfgBuried = bur; cfgOeSel = oe;
    for (int i = 0; i < 12; i++) step(1, 0, "R6");
    for (int i = 0; i < 40; i++) step(0, 0, tag);
    if (doAsync) begin
      for (int i = 0; i < 12; i++) step(0, 1, "R6");   // preset alone
      for (int i = 0; i < 12; i++) step(1, 1, "R6");   // both: reset wins
      for (int i = 0; i < 3; i++)  step(1, 0, "R6");
      for (int i = 0; i < 20; i++) step(0, 0, tag);
    end
  endtask

  initial begin
    // reset state
    #1;
    @(negedge tick);
    total++;
    if (feedback !== 1'b0 || pinOe !== 1'b0) begin
      bad++;
      $display("FAIL R6 reset state: feedback got %b exp 0, pinOe got %b exp 0", feedback, pinOe);
    end
    // R1, R5: D mode on every clock source, including an alias code
    runPhase(2'b00, 3'd0, 0, 0, 2'd1, 1, "R1");
    runPhase(2'b00, 3'd1, 0, 0, 2'd1, 0, "R5");
    runPhase(2'b00, 3'd2, 0, 0, 2'd1, 0, "R5");
    runPhase(2'b00, 3'd3, 0, 0, 2'd1, 0, "R5");
    runPhase(2'b00, 3'd4, 0, 0, 2'd1, 0, "R5");
    runPhase(2'b00, 3'd7, 0, 0, 2'd1, 0, "R5");
    // R2 toggle, R3 latch, R4 bypass
    runPhase(2'b01, 3'd2, 0, 0, 2'd1, 1, "R2");
    runPhase(2'b01, 3'd4, 1, 0, 2'd0, 0, "R2");
    runPhase(2'b10, 3'd1, 0, 0, 2'd1, 1, "R3");
    runPhase(2'b10, 3'd4, 1, 0, 2'd1, 0, "R3");
    runPhase(2'b11, 3'd0, 0, 0, 2'd1, 1, "R4");
    // R7 polarity
    runPhase(2'b00, 3'd3, 1, 0, 2'd1, 1, "R7");
    // R8 buried input register/latch, R9 feedback in buried bypass
    runPhase(2'b00, 3'd0, 0, 1, 2'd1, 1, "R8");
    runPhase(2'b10, 3'd2, 1, 1, 2'd2, 0, "R8");
    runPhase(2'b11, 3'd4, 1, 1, 2'd3, 0, "R9");
    // R10 enable sources
    runPhase(2'b00, 3'd1, 0, 0, 2'd0, 0, "R10");
    runPhase(2'b00, 3'd1, 0, 0, 2'd2, 0, "R10");
    runPhase(2'b00, 3'd1, 0, 0, 2'd3, 0, "R10");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule